// File: doc/BRIEF.md
# EPROM Pulse-and-Verify Programming Sequencer

This block is the control engine of a device programmer for one-time-programmable parallel memories. After a start request it first reads back the two identification bytes of the attached part under the identification high voltage. If both match, it raises the core supply and then the programming supply. It walks an inclusive address range in ascending order. For each address it fetches the intended byte from a source port indexed by the same address.

Each byte receives one program pulse with no check. It is then read back. While the read-back differs, another pulse is applied and the byte is read again, up to a fixed number of extra pulses. If a byte still differs after the last extra pulse, the run stops and reports a programming failure at that address. When every byte has verified, both supplies return to nominal. The whole range is read once more and compared with the source data. The run ends with a done flag, a pass flag, a failure class and the failing address.

All timing is counted in clock cycles through parameters: pulse width, strobe setup, data hold and read access wait. The supply rails themselves, the high-voltage switch and the memory array lie outside the block.

Top module: `eprom_prog_seq`

## Requirements
- R1: After reset, PGM, CE and OE are high (inactive), the data drivers, both raised supplies and the identification voltage are off, and done is 0.
- R2: A run starts with an identification check: with id_hv high and every address line low, A0=0 must read 0x1E and A0=1 must read 0x86. On a mismatch the run ends with done=1, pass=0, fail_kind=1 and fail_addr=0. In that case no program pulse is applied and the programming supply is never raised.
- R3: core_hi rises at least SETUP_CYC cycles before prog_hi rises, prog_hi is never high while core_hi is low, and prog_hi has been high for at least SETUP_CYC cycles before the first pulse.
- R4: Every program pulse keeps dev_pgm_n low for exactly PULSE_CYC cycles.
- R5: Address, data, CE and OE are stable, with the data drivers on, for at least SETUP_CYC cycles before PGM falls. The data stays driven and unchanged for at least HOLD_CYC cycles after PGM rises.
- R6: Each address receives one unchecked pulse, then a read-back after every pulse. A byte that needs k pulses (1 <= k <= MAX_RETRY+1) receives exactly k pulses.
- R7: A byte that still mismatches after 1+MAX_RETRY pulses ends the run with fail_kind=2 and fail_addr set to that address, and no later address is pulsed.
- R8: The data drivers (dev_doe) are never on while dev_oe_n is low.
- R9: After programming, both supplies are lowered and every byte of the range is read again. The first mismatch ends the run with fail_kind=3 and fail_addr set to that address.
- R10: A run that completes every stage ends with done=1, pass=1 and fail_kind=0.
- R11: Only addresses from first_addr to last_addr inclusive are programmed, in ascending order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a run when the block is idle |
| first_addr | input | 18 | First address of the range |
| last_addr | input | 18 | Last address of the range (inclusive) |
| src_addr | output | 18 | Address of the requested source byte |
| src_data | input | 8 | Intended byte for src_addr, same cycle |
| dev_addr | output | 18 | Device address lines |
| dev_dout | output | 8 | Data driven toward the device |
| dev_doe | output | 1 | Enables the data drivers |
| dev_din | input | 8 | Data read from the device |
| dev_ce_n | output | 1 | Device chip enable, active low |
| dev_oe_n | output | 1 | Device output enable, active low |
| dev_pgm_n | output | 1 | Program strobe, active low |
| id_hv | output | 1 | Requests the identification high voltage |
| core_hi | output | 1 | Requests the raised core supply |
| prog_hi | output | 1 | Requests the programming supply |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Result valid; cleared by the next start |
| pass | output | 1 | Run passed |
| fail_addr | output | 18 | Address of the failure |
| fail_kind | output | 2 | 0 none, 1 identification, 2 programming, 3 final compare |

## Verification
The device model needs a configurable number of pulses per byte before the byte takes its value. Bytes that need one pulse, several pulses, exactly the last allowed pulse and one pulse more are all tried. A sequencer with an off-by-one retry bound either fails a byte that should pass or applies an extra pulse. Wrong identification codes must stop the run before the programming supply rises; a design that checked them late would stress a part of the wrong kind. A byte that reads wrong only at nominal supply must be caught by the final compare; a design that skipped that pass would report success. A sub-range away from address zero exposes walkers that ignore the range bounds.

// File: rtl/eprom_prog_pkg.sv
package eprom_prog_pkg;

    typedef enum logic [1:0] {
        FK_NONE = 2'd0,
        FK_ID   = 2'd1,
        FK_PROG = 2'd2,
        FK_CMP  = 2'd3
    } fail_kind_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ID_LO,
        ST_ID_HI,
        ST_PWR_CORE,
        ST_PWR_PROG,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_VERIFY,
        ST_LOWER,
        ST_READBACK
    } seq_state_t;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic pgm_n;
        logic drive;
        logic hv_id;
        logic core_up;
        logic prog_up;
    } strobe_t;

    localparam logic [7:0] MFR_CODE_DEF = 8'h1E;
    localparam logic [7:0] DEV_CODE_DEF = 8'h86;

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic strobe_t strobes_for(input seq_state_t s);
        strobe_t o;
        o = '{ce_n: 1'b1, oe_n: 1'b1, pgm_n: 1'b1, drive: 1'b0,
               hv_id: 1'b0, core_up: 1'b0, prog_up: 1'b0};
        case (s)
            ST_ID_LO, ST_ID_HI: begin
                o.ce_n  = 1'b0;
                o.oe_n  = 1'b0;
                o.hv_id = 1'b1;
            end
            ST_PWR_CORE: o.core_up = 1'b1;
            ST_PWR_PROG: begin
                o.core_up = 1'b1;
                o.prog_up = 1'b1;
            end
            ST_SETUP, ST_HOLD: begin
                o.ce_n    = 1'b0;
                o.drive   = 1'b1;
                o.core_up = 1'b1;
                o.prog_up = 1'b1;
            end
            ST_PULSE: begin
                o.ce_n    = 1'b0;
                o.pgm_n   = 1'b0;
                o.drive   = 1'b1;
                o.core_up = 1'b1;
                o.prog_up = 1'b1;
            end
            ST_VERIFY: begin
                o.ce_n    = 1'b0;
                o.oe_n    = 1'b0;
                o.core_up = 1'b1;
                o.prog_up = 1'b1;
            end
            ST_READBACK: begin
                o.ce_n = 1'b0;
                o.oe_n = 1'b0;
            end
            default: ;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/eprom_interval_timer.sv
module eprom_interval_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // a loaded count must run down one step per cycle
    AST_TMR_DOWN: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R4
endmodule

// File: rtl/eprom_addr_walker.sv
module eprom_addr_walker #(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_first,
    input  logic [AW-1:0] load_last,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          at_last
);
    logic [AW-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr   <= '0;
            last_q <= '0;
        end else if (load) begin
            addr   <= load_first;
            last_q <= load_last;
        end else if (step) begin
            addr <= addr + 1'b1;
        end
    end

    assign at_last = (addr == last_q);

    AST_WALK_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        step |-> !at_last); // R11
    AST_WALK_ASCEND: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (addr == $past(addr) + 1'b1)); // R11
endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
    import eprom_prog_pkg::*;
#(
    parameter int AW          = 18,
    parameter int DW          = 8,
    parameter int PULSE_CYC   = 12500,
    parameter int SETUP_CYC   = 250,
    parameter int HOLD_CYC    = 250,
    parameter int VERIFY_CYC  = 19,
    parameter int MAX_RETRY   = 10,
    parameter logic [DW-1:0] MFR_CODE = DW'(MFR_CODE_DEF),
    parameter logic [DW-1:0] DEV_CODE = DW'(DEV_CODE_DEF)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] first_addr,
    input  logic [AW-1:0] last_addr,
    output logic [AW-1:0] src_addr,
    input  logic [DW-1:0] src_data,
    output logic [AW-1:0] dev_addr,
    output logic [DW-1:0] dev_dout,
    output logic          dev_doe,
    input  logic [DW-1:0] dev_din,
    output logic          dev_ce_n,
    output logic          dev_oe_n,
    output logic          dev_pgm_n,
    output logic          id_hv,
    output logic          core_hi,
    output logic          prog_hi,
    output logic          busy,
    output logic          done,
    output logic          pass,
    output logic [AW-1:0] fail_addr,
    output logic [1:0]    fail_kind
);
    localparam int TMAX = int'(max4(PULSE_CYC, SETUP_CYC, HOLD_CYC, VERIFY_CYC));
    localparam int TW   = $clog2(TMAX + 1);
    localparam int RW   = $clog2(MAX_RETRY + 1);
    localparam int PW   = $clog2(PULSE_CYC + 2);
    localparam logic [TW-1:0] T_PULSE = TW'(PULSE_CYC - 1);
    localparam logic [TW-1:0] T_SETUP = TW'(SETUP_CYC - 1);
    localparam logic [TW-1:0] T_HOLD  = TW'(HOLD_CYC - 1);
    localparam logic [TW-1:0] T_READ  = TW'(VERIFY_CYC - 1);
    localparam logic [RW-1:0] R_LIMIT = RW'(MAX_RETRY);

    seq_state_t    st, st_n;
    strobe_t       sb;
    fail_kind_t    fk_q, fk_n;
    logic          t_ld, t_zero;
    logic [TW-1:0] t_val;
    logic          w_load, w_step, w_last;
    logic [AW-1:0] w_addr;
    logic          fin_ok, fin_fail;
    logic          retry_clr, retry_inc;
    logic [RW-1:0] retry_q;
    logic [PW-1:0] pgm_lo_cnt;
    logic          byte_ok;

    eprom_interval_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_ld),
        .load_val (t_val),
        .expired  (t_zero)
    );

    eprom_addr_walker #(.AW(AW)) u_walker (
        .clk        (clk),
        .rst        (rst),
        .load       (w_load),
        .load_first (first_addr),
        .load_last  (last_addr),
        .step       (w_step),
        .addr       (w_addr),
        .at_last    (w_last)
    );

    assign byte_ok = (dev_din == src_data);

    always_comb begin
        st_n      = st;
        t_ld      = 1'b0;
        t_val     = '0;
        w_load    = 1'b0;
        w_step    = 1'b0;
        fin_ok    = 1'b0;
        fin_fail  = 1'b0;
        fk_n      = FK_NONE;
        retry_clr = 1'b0;
        retry_inc = 1'b0;
        case (st)
            ST_IDLE: if (start) begin
                st_n = ST_ID_LO; t_ld = 1'b1; t_val = T_READ; w_load = 1'b1;
            end
            ST_ID_LO: if (t_zero) begin
                if (dev_din == MFR_CODE) begin
                    st_n = ST_ID_HI; t_ld = 1'b1; t_val = T_READ;
                end else begin
                    fin_fail = 1'b1; fk_n = FK_ID;
                end
            end
            ST_ID_HI: if (t_zero) begin
                if (dev_din == DEV_CODE) begin
                    st_n = ST_PWR_CORE; t_ld = 1'b1; t_val = T_SETUP;
                end else begin
                    fin_fail = 1'b1; fk_n = FK_ID;
                end
            end
            ST_PWR_CORE: if (t_zero) begin
                st_n = ST_PWR_PROG; t_ld = 1'b1; t_val = T_SETUP;
            end
            ST_PWR_PROG: if (t_zero) begin
                st_n = ST_SETUP; t_ld = 1'b1; t_val = T_SETUP; retry_clr = 1'b1;
            end
            ST_SETUP: if (t_zero) begin
                st_n = ST_PULSE; t_ld = 1'b1; t_val = T_PULSE;
            end
            ST_PULSE: if (t_zero) begin
                st_n = ST_HOLD; t_ld = 1'b1; t_val = T_HOLD;
            end
            ST_HOLD: if (t_zero) begin
                st_n = ST_VERIFY; t_ld = 1'b1; t_val = T_READ;
            end
            ST_VERIFY: if (t_zero) begin
                if (byte_ok) begin
                    t_ld = 1'b1;
                    t_val = T_SETUP;
                    if (w_last) begin
                        st_n = ST_LOWER;
                    end else begin
                        st_n = ST_SETUP; w_step = 1'b1; retry_clr = 1'b1;
                    end
                end else if (retry_q == R_LIMIT) begin
                    fin_fail = 1'b1; fk_n = FK_PROG;
                end else begin
                    st_n = ST_SETUP; t_ld = 1'b1; t_val = T_SETUP; retry_inc = 1'b1;
                end
            end
            ST_LOWER: if (t_zero) begin
                st_n = ST_READBACK; t_ld = 1'b1; t_val = T_READ; w_load = 1'b1;
            end
            ST_READBACK: if (t_zero) begin
                if (!byte_ok) begin
                    fin_fail = 1'b1; fk_n = FK_CMP;
                end else if (w_last) begin
                    fin_ok = 1'b1;
                end else begin
                    w_step = 1'b1; t_ld = 1'b1; t_val = T_READ;
                end
            end
            default: st_n = ST_IDLE;
        endcase
        if (fin_ok || fin_fail) st_n = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            done      <= 1'b0;
            pass      <= 1'b0;
            fail_addr <= '0;
            fk_q      <= FK_NONE;
            retry_q   <= '0;
        end else begin
            st <= st_n;
            if (st == ST_IDLE && start) begin
                done      <= 1'b0;
                pass      <= 1'b0;
                fail_addr <= '0;
                fk_q      <= FK_NONE;
            end
            if (fin_ok) begin
                done <= 1'b1;
                pass <= 1'b1;
            end
            if (fin_fail) begin
                done      <= 1'b1;
                pass      <= 1'b0;
                fk_q      <= fk_n;
                fail_addr <= (fk_n == FK_ID) ? '0 : w_addr;
            end
            if (retry_clr)
                retry_q <= '0;
            else if (retry_inc)
                retry_q <= retry_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            pgm_lo_cnt <= '0;
        else if (!dev_pgm_n)
            pgm_lo_cnt <= pgm_lo_cnt + 1'b1;
        else
            pgm_lo_cnt <= '0;
    end

    assign sb        = strobes_for(st);
    assign dev_ce_n  = sb.ce_n;
    assign dev_oe_n  = sb.oe_n;
    assign dev_pgm_n = sb.pgm_n;
    assign dev_doe   = sb.drive;
    assign id_hv     = sb.hv_id;
    assign core_hi   = sb.core_up;
    assign prog_hi   = sb.prog_up;
    assign dev_addr  = sb.hv_id ? AW'(st == ST_ID_HI) : w_addr;
    assign dev_dout  = sb.drive ? src_data : '0;
    assign src_addr  = w_addr;
    assign busy      = (st != ST_IDLE);
    assign fail_kind = fk_q;

    AST_PROG_NEEDS_CORE: assert property (@(posedge clk) disable iff (rst)
        prog_hi |-> core_hi); // R3
    AST_CORE_BEFORE_PROG: assert property (@(posedge clk) disable iff (rst)
        $rose(prog_hi) |-> $past(core_hi)); // R3
    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (rst)
        !dev_oe_n |-> !dev_doe); // R8
    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(dev_pgm_n) |-> (pgm_lo_cnt == PW'(PULSE_CYC))); // R4
    AST_SETUP_STABLE: assert property (@(posedge clk) disable iff (rst)
        $fell(dev_pgm_n) |-> ($past(dev_doe) && $stable(dev_addr) && $stable(dev_dout))); // R5
    AST_HOLD_START: assert property (@(posedge clk) disable iff (rst)
        $rose(dev_pgm_n) |-> (dev_doe && $stable(dev_dout) && $stable(dev_addr))); // R5
    AST_ID_LOW_SUPPLY: assert property (@(posedge clk) disable iff (rst)
        id_hv |-> (!prog_hi && dev_pgm_n)); // R2
    AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (rst)
        retry_q <= R_LIMIT); // R7
    AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (done && pass) |-> (fail_kind == 2'd0)); // R10
endmodule

// File: tb/test_eprom_prog_seq.sv
module test_eprom_prog_seq;
    localparam int AW = 18;
    localparam int PULSE = 20;
    localparam int SETUP = 4;
    localparam int HOLD  = 4;
    localparam int RDW   = 3;
    localparam int RETRY = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] first_addr = '0;
    logic [AW-1:0] last_addr = '0;
    logic [AW-1:0] src_addr;
    logic [7:0]    src_data;
    logic [AW-1:0] dev_addr;
    logic [7:0]    dev_dout;
    logic          dev_doe;
    logic [7:0]    dev_din;
    logic          dev_ce_n, dev_oe_n, dev_pgm_n, id_hv, core_hi, prog_hi;
    logic          busy, done, pass;
    logic [AW-1:0] fail_addr;
    logic [1:0]    fail_kind;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    eprom_prog_seq #(
        .AW(AW), .DW(8), .PULSE_CYC(PULSE), .SETUP_CYC(SETUP),
        .HOLD_CYC(HOLD), .VERIFY_CYC(RDW), .MAX_RETRY(RETRY)
    ) i_eprom_prog_seq (
        .clk(clk), .rst(rst), .start(start),
        .first_addr(first_addr), .last_addr(last_addr),
        .src_addr(src_addr), .src_data(src_data),
        .dev_addr(dev_addr), .dev_dout(dev_dout), .dev_doe(dev_doe),
        .dev_din(dev_din), .dev_ce_n(dev_ce_n), .dev_oe_n(dev_oe_n),
        .dev_pgm_n(dev_pgm_n), .id_hv(id_hv), .core_hi(core_hi),
        .prog_hi(prog_hi), .busy(busy), .done(done), .pass(pass),
        .fail_addr(fail_addr), .fail_kind(fail_kind)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input logic [AW-1:0] a);
        return {1'b0, a[6:0] ^ 7'h35};
    endfunction

    assign src_data = pat(src_addr);

    // device model configuration (written by the driver only)
    int         need [64];
    logic [7:0] mfr_code = 8'h1E;
    logic [7:0] dev_code = 8'h86;
    bit         corrupt_en = 1'b0;
    logic [5:0] corrupt_a = '0;
    bit         clr_req = 1'b0;

    // device model state (written by the model only)
    logic [7:0] mem [64];
    int         pcnt [64];
    bit         vpp_seen;

    always_comb begin
        dev_din = 8'h00;
        if (!dev_ce_n && !dev_oe_n) begin
            if (id_hv)
                dev_din = dev_addr[0] ? dev_code : mfr_code;
            else begin
                dev_din = mem[dev_addr[5:0]];
                if (corrupt_en && !prog_hi && dev_addr[5:0] == corrupt_a)
                    dev_din = dev_din ^ 8'h01;
            end
        end
    end

    bit          pgm_prev = 1'b1, prog_prev = 1'b0, in_hold = 1'b0;
    int          core_cnt = 0, prog_cnt = 0, lo_cnt = 0, stab = 0, hcnt = 0;
    logic [7:0]  hdata = '0;
    logic [AW+11:0] sig_prev = '0;

    always @(negedge clk) begin : model
        logic [AW+11:0] sig;
        if (clr_req) begin
            for (int i = 0; i < 64; i++) begin
                mem[i]  = 8'hFF;
                pcnt[i] = 0;
            end
            vpp_seen = 1'b0;
        end else if (!rst) begin
            if (!dev_oe_n && dev_doe) chk(1'b0, "R8 drivers on while OE low", 1, 0);
            if (prog_hi && !core_hi) chk(1'b0, "R3 prog supply without core", 0, 1);
            if (prog_hi) vpp_seen = 1'b1;
            if (prog_hi && !prog_prev) chk(core_cnt >= SETUP, "R3 core lead time", core_cnt, SETUP);
            sig = {dev_addr, dev_dout, dev_ce_n, dev_oe_n, dev_doe, id_hv};
            if (dev_doe && sig == sig_prev) stab++; else stab = 0;
            if (!dev_pgm_n && pgm_prev) begin
                chk(prog_cnt >= SETUP, "R3 prog supply settle", prog_cnt, SETUP);
                chk(stab >= SETUP, "R5 setup before pulse", stab, SETUP);
            end
            if (dev_pgm_n && !pgm_prev) begin
                chk(lo_cnt == PULSE, "R4 pulse width", lo_cnt, PULSE);
                pcnt[dev_addr[5:0]]++;
                if (pcnt[dev_addr[5:0]] >= need[dev_addr[5:0]])
                    mem[dev_addr[5:0]] = mem[dev_addr[5:0]] & dev_dout;
                in_hold = 1'b1;
                hcnt = 1;
                hdata = dev_dout;
            end else if (in_hold) begin
                if (dev_doe && dev_dout == hdata) hcnt++;
                else begin
                    chk(hcnt >= HOLD, "R5 hold after pulse", hcnt, HOLD);
                    in_hold = 1'b0;
                end
            end
            sig_prev = sig;
            core_cnt = core_hi ? core_cnt + 1 : 0;
            prog_cnt = prog_hi ? prog_cnt + 1 : 0;
            lo_cnt   = !dev_pgm_n ? lo_cnt + 1 : 0;
            pgm_prev = dev_pgm_n;
            prog_prev = prog_hi;
        end
    end

    // scoreboard
    typedef struct {
        string req;
        bit    pass;
        int    kind;
        int    addr;
    } exp_t;
    exp_t exp_q[$];

    initial begin : monitor
        bit done_q = 1'b0;
        exp_t e;
        forever begin
            @(negedge clk);
            if (done && !done_q) begin
                if (exp_q.size() == 0) chk(1'b0, "R10 unexpected result", 0, 1);
                else begin
                    e = exp_q.pop_front();
                    chk(pass == e.pass, {e.req, " pass flag"}, int'(pass), int'(e.pass));
                    chk(int'(fail_kind) == e.kind, {e.req, " fail_kind"}, int'(fail_kind), e.kind);
                    chk(int'(fail_addr) == e.addr, {e.req, " fail_addr"}, int'(fail_addr), e.addr);
                end
            end
            done_q = done;
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic prep();
        for (int i = 0; i < 64; i++) need[i] = 1;
        mfr_code = 8'h1E;
        dev_code = 8'h86;
        corrupt_en = 1'b0;
        clr_req = 1'b1;
        tick();
        clr_req = 1'b0;
    endtask

    task automatic run(input string req, input int f, input int l,
                       input bit p, input int kind, input int fa);
        exp_t e;
        e.req = req; e.pass = p; e.kind = kind; e.addr = fa;
        exp_q.push_back(e);
        first_addr = AW'(f);
        last_addr  = AW'(l);
        start = 1'b1;
        tick();
        start = 1'b0;
        while (!done) tick();
        repeat (3) tick();
    endtask

    task automatic pulses(input string req, input int lo, input int hi, input int n);
        for (int a = lo; a <= hi; a++)
            chk(pcnt[a] == n, req, pcnt[a], n);
    endtask

    initial begin : driver
        repeat (5) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk(dev_pgm_n && dev_ce_n && dev_oe_n, "R1 strobes idle", 0, 1);
        chk(!dev_doe && !core_hi && !prog_hi && !id_hv, "R1 drivers and supplies off", 0, 1);
        chk(!done && !busy, "R1 done and busy low", int'(done), 0);

        // R10 R11 R6: plain range, one pulse each
        prep();
        run("R10 plain pass", 0, 7, 1'b1, 0, 0);
        pulses("R6 single pulse", 0, 7, 1);
        for (int a = 0; a < 8; a++)
            chk(mem[a] == pat(AW'(a)), "R6 programmed content", int'(mem[a]), int'(pat(AW'(a))));
        chk(vpp_seen, "R3 prog supply used", 0, 1);

        // R6 R7: slow bytes, including the last allowed pulse
        prep();
        need[3] = 5;
        need[5] = RETRY + 1;
        run("R6 slow bytes pass", 0, 7, 1'b1, 0, 0);
        chk(pcnt[3] == 5, "R6 five pulses", pcnt[3], 5);
        chk(pcnt[5] == RETRY + 1, "R7 last allowed pulse", pcnt[5], RETRY + 1);
        pulses("R6 others single", 6, 7, 1);

        // R7: one pulse beyond the limit
        prep();
        need[2] = RETRY + 2;
        run("R7 retry exhausted", 0, 7, 1'b0, 2, 2);
        chk(pcnt[2] == RETRY + 1, "R7 pulse count at failing byte", pcnt[2], RETRY + 1);
        pulses("R7 earlier bytes", 0, 1, 1);
        pulses("R7 no later bytes", 3, 7, 0);

        // R2: wrong manufacturer code
        prep();
        mfr_code = 8'h1F;
        run("R2 manufacturer mismatch", 0, 7, 1'b0, 1, 0);
        pulses("R2 no pulses", 0, 7, 0);
        chk(!vpp_seen, "R2 prog supply stays off", int'(vpp_seen), 0);

        // R2: wrong device code
        prep();
        dev_code = 8'h87;
        run("R2 device mismatch", 4, 9, 1'b0, 1, 0);
        pulses("R2 no pulses dev", 4, 9, 0);
        chk(!vpp_seen, "R2 prog supply stays off dev", int'(vpp_seen), 0);

        // R9: byte wrong only at nominal supply
        prep();
        corrupt_en = 1'b1;
        corrupt_a  = 6'd6;
        run("R9 final compare failure", 0, 7, 1'b0, 3, 6);
        pulses("R9 programming was clean", 0, 7, 1);

        // R11: sub-range away from zero
        prep();
        run("R11 sub-range pass", 10, 12, 1'b1, 0, 0);
        pulses("R11 inside range", 10, 12, 1);
        pulses("R11 below range", 9, 9, 0);
        pulses("R11 above range", 13, 13, 0);

        chk(exp_q.size() == 0, "R10 all results seen", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule